// File: doc/BRIEF.md
# Queued SPI Command Sequencer

This block runs a queue of SPI transfers from a 16-entry command RAM. Each entry holds a chip-select pattern and an 8-bit transmit word. Software loads the entries and sets a first and a last pointer in a control register. A start pulse then makes the block walk the queue, one entry at a time. For each entry it shifts the word out on an internal SPI shift engine and stores the received byte in a receive RAM at the same index.

The walk can stop in two ways. It stops after the last entry, or it stops after the entry in progress when the halt bit is set. It can also wrap back to entry zero or to the first pointer and keep going. A read-only field in the control word always shows the index of the most recently finished entry. When the walk stops, the block gives a one-cycle `done` pulse and sets a sticky `finished` flag. While no transfer is in progress, every chip-select line sits at a programmable idle level.

Top module: `qspi_queue_seq`

## Requirements
- R1: After reset, `ctl_rdata` reads all zeros, `cs_o` is 0, and `finished`, `done`, `sclk` and `xfer_active` are all low.
- R2: A start pulse while idle begins at the entry named by the first pointer (`ctl` bits 3:0). Entries run in ascending index order, and the index goes from 15 to 0 when the first pointer is greater than the last pointer (bits 7:4). With the wrap bit (bit 13) clear, the walk stops after the last-pointer entry has completed.
- R3: A command word is {chip-select pattern in bits 11:8, transmit byte in bits 7:0}. Each entry shifts its byte MSB first on `mosi`. `sclk` idles low, and `miso` is sampled on the rising `sclk`. The byte received for entry i is written to receive RAM index i.
- R4: While `xfer_active` is high, `cs_o` equals the pattern of the current entry and holds steady for that whole entry. At all other times every `cs_o` bit equals the idle-level bit (bit 15).
- R5: When the halt bit (bit 12) is set, the block completes all 8 bits of the entry in progress and then stops. A start while halt is set runs exactly one entry.
- R6: With wrap set and the wrap-target bit (bit 14) clear, the entry after the last-pointer entry is entry 0.
- R7: With wrap set and the wrap-target bit set, the entry after the last-pointer entry is the first-pointer entry.
- R8: `ctl_rdata` bits 11:8 show the index of the most recently completed entry. The field is updated at the end of every entry.
- R9: When the walk stops, `done` is high for exactly one cycle and `finished` goes high with it. `finished` stays high until the next accepted start.
- R10: A start pulse that arrives while a walk is running is ignored.
- R11: Control bits 15:12 and 7:0 read back as written. Writes to bits 11:8 have no effect on what those bits read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word readback, including the completed-entry index |
| cmd_we | input | 1 | Command RAM write enable |
| cmd_addr | input | 4 | Command RAM write index |
| cmd_wdata | input | 12 | Command entry {cs pattern, tx byte} |
| start | input | 1 | Start pulse |
| rx_addr | input | 4 | Receive RAM read index |
| rx_data | output | 8 | Receive RAM read data |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI serial data out |
| miso | input | 1 | SPI serial data in |
| cs_o | output | 4 | Chip-select lines |
| xfer_active | output | 1 | High while an entry's transfer is being driven |
| done | output | 1 | One-cycle pulse when the walk stops |
| finished | output | 1 | Sticky stop flag, cleared by start |

## Verification
The bench builds the block with its default parameters: 16 entries, 4 chip-select lines and 8-bit words. With 16 entries, a first pointer above the last pointer makes the index roll over from 15 to 0. Full 16-entry queues, wrap to zero and wrap to the first pointer then all run in a few thousand cycles. With `miso` looped back to `mosi`, each received byte equals the sent byte, so the receive RAM can be checked against the bench's own list of words. An inverted loopback run shows that the receive RAM holds what came in on `miso`, not a copy of what went out.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LOAD  = 2'd1,
    SEQ_SHIFT = 2'd2,
    SEQ_NEXT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/qseq_regfile.sv
module qseq_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 12,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/qseq_shifter.sv
module qseq_shifter #(
  parameter int DATA_W = 8,
  localparam int CW = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi
);
  localparam logic [CW-1:0] LAST = CW'(2 * DATA_W - 1);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              sclk_q, sclk_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (!busy_q) begin
      if (go) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        tx_d   = tx_word;
        sclk_d = 1'b0;
      end
    end else begin
      cnt_d = cnt_q + CW'(1);
      if (!cnt_q[0]) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[DATA_W-2:0], miso};
      end else begin
        sclk_d = 1'b0;
        tx_d   = {tx_q[DATA_W-2:0], 1'b0};
        if (cnt_q == LAST) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      sclk_q <= sclk_d;
      cnt_q  <= cnt_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[DATA_W-1];
endmodule

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
  import qspi_seq_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int CS_W      = 4,
  parameter int DATA_W    = 8,
  localparam int PW = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PW-1:0]     cfg_first,
  input  logic [PW-1:0]     cfg_last,
  input  logic              cfg_halt,
  input  logic              cfg_wrap,
  input  logic              cfg_wrap_first,
  output logic [PW-1:0]     cmd_raddr,
  input  logic [CS_W-1:0]   cmd_cs,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              eng_go,
  output logic [DATA_W-1:0] eng_tx,
  input  logic              eng_done,
  output logic              rx_we,
  output logic [PW-1:0]     rx_waddr,
  output logic              active,
  output logic [CS_W-1:0]   ent_cs,
  output logic [PW-1:0]     cpt,
  output logic              seq_done,
  output logic              seq_finished
);
  localparam logic [PW-1:0] TOP_IDX = PW'(N_ENTRIES - 1);

  seq_state_e        state_q, state_d;
  logic [PW-1:0]     cur_q, cur_d;
  logic [PW-1:0]     cpt_q, cpt_d;
  logic [CS_W-1:0]   cs_q, cs_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              done_q, done_d;
  logic              fin_q, fin_d;
  logic [PW-1:0]     nxt_ptr;
  logic              at_last, stop_now, load_en;

  assign at_last  = (cur_q == cfg_last);
  assign stop_now = cfg_halt || (at_last && !cfg_wrap);

  always_comb begin
    if (at_last)                nxt_ptr = cfg_wrap_first ? cfg_first : '0;
    else if (cur_q == TOP_IDX)  nxt_ptr = '0;
    else                        nxt_ptr = cur_q + PW'(1);
  end

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    cpt_d   = cpt_q;
    done_d  = 1'b0;
    fin_d   = fin_q;
    eng_go  = 1'b0;
    rx_we   = 1'b0;
    load_en = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_LOAD;
          cur_d   = cfg_first;
          load_en = 1'b1;
          fin_d   = 1'b0;
        end
      end
      SEQ_LOAD: begin
        eng_go  = 1'b1;
        state_d = SEQ_SHIFT;
      end
      SEQ_SHIFT: begin
        if (eng_done) begin
          rx_we   = 1'b1;
          cpt_d   = cur_q;
          state_d = SEQ_NEXT;
        end
      end
      SEQ_NEXT: begin
        if (stop_now) begin
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
          fin_d   = 1'b1;
        end else begin
          cur_d   = nxt_ptr;
          load_en = 1'b1;
          state_d = SEQ_LOAD;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
    cs_d  = load_en ? cmd_cs   : cs_q;
    dat_d = load_en ? cmd_data : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cur_q   <= '0;
      cpt_q   <= '0;
      cs_q    <= '0;
      dat_q   <= '0;
      done_q  <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      cpt_q   <= cpt_d;
      cs_q    <= cs_d;
      dat_q   <= dat_d;
      done_q  <= done_d;
      fin_q   <= fin_d;
    end
  end

  assign cmd_raddr    = (state_q == SEQ_IDLE) ? cfg_first : nxt_ptr;
  assign eng_tx       = dat_q;
  assign rx_waddr     = cur_q;
  assign active       = (state_q == SEQ_LOAD) || (state_q == SEQ_SHIFT);
  assign ent_cs       = cs_q;
  assign cpt          = cpt_q;
  assign seq_done     = done_q;
  assign seq_finished = fin_q;
endmodule

// File: rtl/qspi_queue_seq.sv
module qspi_queue_seq
  import qspi_seq_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int CS_W      = 4,
  parameter int DATA_W    = 8,
  localparam int PW    = $clog2(N_ENTRIES),
  localparam int CTL_W = 3 * PW + 4,
  localparam int CMD_W = CS_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              cmd_we,
  input  logic [PW-1:0]     cmd_addr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              start,
  input  logic [PW-1:0]     rx_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_W-1:0]   cs_o,
  output logic              xfer_active,
  output logic              done,
  output logic              finished
);
  localparam int F_LAST = PW;
  localparam int F_CPT  = 2 * PW;
  localparam int B_HALT = 3 * PW;
  localparam int B_WRAP = 3 * PW + 1;
  localparam int B_WTO  = 3 * PW + 2;
  localparam int B_IDLE = 3 * PW + 3;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [PW-1:0] first_q, last_q;
  logic          halt_q, wrap_q, wto_q, idle_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      first_q <= '0;
      last_q  <= '0;
      halt_q  <= 1'b0;
      wrap_q  <= 1'b0;
      wto_q   <= 1'b0;
      idle_q  <= 1'b0;
    end else if (ctl_we) begin
      first_q <= ctl_wdata[PW-1:0];
      last_q  <= ctl_wdata[F_LAST +: PW];
      halt_q  <= ctl_wdata[B_HALT];
      wrap_q  <= ctl_wdata[B_WRAP];
      wto_q   <= ctl_wdata[B_WTO];
      idle_q  <= ctl_wdata[B_IDLE];
    end
  end

  logic unused_cpt_wr;
  assign unused_cpt_wr = ^ctl_wdata[F_CPT +: PW];

  logic [PW-1:0]     cmd_raddr, rx_waddr, cpt;
  logic [CMD_W-1:0]  cmd_rdata;
  logic              eng_go, eng_done, eng_busy, rx_we, active;
  logic [DATA_W-1:0] eng_tx, eng_rx;
  logic [CS_W-1:0]   ent_cs;

  qseq_regfile #(.DEPTH(N_ENTRIES), .WIDTH(CMD_W)) u_cmd_ram (
    .clk   (clk),
    .we    (cmd_we),
    .waddr (cmd_addr),
    .wdata (cmd_wdata),
    .raddr (cmd_raddr),
    .rdata (cmd_rdata)
  );

  qseq_regfile #(.DEPTH(N_ENTRIES), .WIDTH(DATA_W)) u_rx_ram (
    .clk   (clk),
    .we    (rx_we),
    .waddr (rx_waddr),
    .wdata (eng_rx),
    .raddr (rx_addr),
    .rdata (rx_data)
  );

  qseq_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .go      (eng_go),
    .tx_word (eng_tx),
    .miso    (miso),
    .busy    (eng_busy),
    .done    (eng_done),
    .rx_word (eng_rx),
    .sclk    (sclk),
    .mosi    (mosi)
  );

  logic unused_busy;
  assign unused_busy = eng_busy;

  qseq_ctrl #(.N_ENTRIES(N_ENTRIES), .CS_W(CS_W), .DATA_W(DATA_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .start          (start),
    .cfg_first      (first_q),
    .cfg_last       (last_q),
    .cfg_halt       (halt_q),
    .cfg_wrap       (wrap_q),
    .cfg_wrap_first (wto_q),
    .cmd_raddr      (cmd_raddr),
    .cmd_cs         (cmd_rdata[CMD_W-1 -: CS_W]),
    .cmd_data       (cmd_rdata[DATA_W-1:0]),
    .eng_go         (eng_go),
    .eng_tx         (eng_tx),
    .eng_done       (eng_done),
    .rx_we          (rx_we),
    .rx_waddr       (rx_waddr),
    .active         (active),
    .ent_cs         (ent_cs),
    .cpt            (cpt),
    .seq_done       (done),
    .seq_finished   (finished)
  );

  generate
    for (genvar g = 0; g < CS_W; g++) begin : g_cs
      assign cs_o[g] = active ? ent_cs[g] : idle_q;
    end
  endgenerate

  assign xfer_active = active;

  always_comb begin
    ctl_rdata                 = '0;
    ctl_rdata[PW-1:0]         = first_q;
    ctl_rdata[F_LAST +: PW]   = last_q;
    ctl_rdata[F_CPT +: PW]    = cpt;
    ctl_rdata[B_HALT]         = halt_q;
    ctl_rdata[B_WRAP]         = wrap_q;
    ctl_rdata[B_WTO]          = wto_q;
    ctl_rdata[B_IDLE]         = idle_q;
  end
endmodule

// File: rtl/qspi_queue_seq_chk.sv
module qspi_queue_seq_chk #(
  parameter int CS_W = 4
) (
  input logic            clk,
  input logic            rst_ni,
  input logic            xfer_active,
  input logic [CS_W-1:0] cs_o,
  input logic            sclk,
  input logic            done,
  input logic            finished
);
  a_r4_cs_steady: assert property (@(posedge clk) disable iff (!rst_ni)
    (xfer_active && $past(xfer_active)) |-> $stable(cs_o));

  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_ni)
    !xfer_active |-> !sclk);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  a_r9_done_sets_finished: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> finished);

  a_r9_finished_clears_on_start: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(finished) |-> xfer_active);

  a_r5_stop_when_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !xfer_active);
endmodule

bind qspi_queue_seq qspi_queue_seq_chk #(.CS_W(CS_W)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .xfer_active (xfer_active),
  .cs_o        (cs_o),
  .sclk        (sclk),
  .done        (done),
  .finished    (finished)
);

// File: tb/qspi_queue_seq_bench.sv
module qspi_queue_seq_bench;
  localparam int CS_W = 4;
  localparam int DW   = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [15:0] ctl_wdata, ctl_rdata;
  logic        cmd_we;
  logic [3:0]  cmd_addr;
  logic [11:0] cmd_wdata;
  logic        start;
  logic [3:0]  rx_addr;
  logic [7:0]  rx_data;
  logic        sclk, mosi, miso, xfer_active, done, finished;
  logic [3:0]  cs_o;
  logic        inv_miso;

  always #4 clk = ~clk;
  assign miso = mosi ^ inv_miso;

  qspi_queue_seq u_qspi_queue_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .start(start), .rx_addr(rx_addr),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_o(cs_o), .xfer_active(xfer_active), .done(done), .finished(finished)
  );

  int n_run = 0;
  int n_fail = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
  endtask

  function automatic logic [7:0] dat(input int i);
    logic [3:0] ii;
    ii = 4'(i);
    return 8'h3C ^ {ii, ii};
  endfunction

  function automatic logic [3:0] csp(input int i);
    return ~4'(i);
  endfunction

  function automatic logic [15:0] mk(input logic [3:0] st, input logic [3:0] en,
                                     input bit halt, input bit wren,
                                     input bit wto, input bit csiv);
    return {csiv, wto, wren, halt, 4'h0, en, st};
  endfunction

  function automatic int exp_idx(input int st, input int en, input bit wto, input int k);
    int cur;
    cur = st;
    for (int j = 0; j < k; j++) begin
      if (cur == en) cur = wto ? st : 0;
      else           cur = (cur + 1) % 16;
    end
    return cur;
  endfunction

  // monitor
  int         log_cnt = 0;
  logic [7:0] log_byte [64];
  logic [3:0] log_cs   [64];
  int         log_bits [64];
  int         done_cnt = 0;
  int         cs_glitch = 0;
  logic       prev_act = 1'b0;
  logic [7:0] mon_byte = 8'h00;
  int         mon_bits = 0;
  logic [3:0] mon_cs = 4'h0;

  always @(posedge sclk) begin
    mon_byte = {mon_byte[6:0], mosi};
    mon_bits++;
  end

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (xfer_active && !prev_act) begin
      mon_bits = 0;
      mon_cs   = cs_o;
    end
    if (xfer_active && prev_act && cs_o != mon_cs) cs_glitch++;
    if (!xfer_active && prev_act && log_cnt < 64) begin
      log_byte[log_cnt] = mon_byte;
      log_cs[log_cnt]   = mon_cs;
      log_bits[log_cnt] = mon_bits;
      log_cnt++;
    end
    prev_act = xfer_active;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R2 watchdog: actual %0h expected %0h", 0, 1);
    report();
    $finish;
  end

  task automatic write_ctl(input logic [15:0] w);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = w;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic run_queue(input int st, input int en, input bit wren, input bit wto,
                           input bit csiv, input bit halt, input int halt_k,
                           input int exp_cnt, input bit restart, input string tag);
    int got;
    int bad_b, bad_c, bad_n, last;
    bit halt_sent, re_sent;
    logic [7:0] rx_exp;
    @(negedge clk);
    log_cnt = 0; done_cnt = 0; cs_glitch = 0;
    write_ctl(mk(4'(st), 4'(en), halt, wren, wto, csiv));
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    halt_sent = 0; re_sent = 0;
    for (int c = 0; c < 20000 && !finished; c++) begin
      @(negedge clk);
      start = 1'b0;
      ctl_we = 1'b0;
      if (restart && !re_sent && log_cnt >= 1) begin
        start = 1'b1;
        re_sent = 1;
      end
      if (halt_k > 0 && !halt_sent && log_cnt >= halt_k) begin
        ctl_we = 1'b1;
        ctl_wdata = mk(4'(st), 4'(en), 1'b1, wren, wto, csiv);
        halt_sent = 1;
      end
    end
    @(negedge clk);
    start = 1'b0; ctl_we = 1'b0;
    got = log_cnt;
    if (exp_cnt > 0) chk(got == exp_cnt, tag, "entry count", got, exp_cnt);
    else chk(got >= halt_k && got <= halt_k + 2, "R5", "entries after halt", got, halt_k);
    bad_b = 0; bad_c = 0; bad_n = 0;
    for (int j = 0; j < got; j++) begin
      if (log_byte[j] != dat(exp_idx(st, en, wto, j))) bad_b++;
      if (log_cs[j]   != csp(exp_idx(st, en, wto, j))) bad_c++;
      if (log_bits[j] != 8) bad_n++;
    end
    chk(bad_b == 0, tag, "entry order / mosi bytes mismatches", bad_b, 0);
    chk(bad_c == 0, "R4", "cs pattern mismatches", bad_c, 0);
    chk(cs_glitch == 0, "R4", "cs changes within an entry", cs_glitch, 0);
    chk(bad_n == 0, "R5", "entries not shifting 8 bits", bad_n, 0);
    last = exp_idx(st, en, wto, got - 1);
    chk(int'(ctl_rdata[11:8]) == last, "R8", "completed index", int'(ctl_rdata[11:8]), last);
    chk(finished == 1'b1, "R9", "finished flag", int'(finished), 1);
    chk(cs_o == {4{csiv}}, "R4", "idle cs level", int'(cs_o), int'({4{csiv}}));
    rx_addr = 4'(last);
    #1;
    rx_exp = dat(last) ^ (inv_miso ? 8'hFF : 8'h00);
    chk(rx_data == rx_exp, "R3", "rx RAM at last entry", int'(rx_data), int'(rx_exp));
    repeat (40) @(negedge clk);
    chk(log_cnt == got, "R5", "no transfers after stop", log_cnt, got);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(finished == 1'b1, "R9", "finished stays set", int'(finished), 1);
  endtask

  // {first[3:0], last[3:0], wrap, wrap_to_first, idle_level, halt_after[3:0]}
  localparam logic [14:0] VEC [7] = '{
    {4'd2,  4'd5,  1'b0, 1'b0, 1'b0, 4'd0},
    {4'd13, 4'd2,  1'b0, 1'b0, 1'b1, 4'd0},
    {4'd7,  4'd7,  1'b0, 1'b0, 1'b0, 4'd0},
    {4'd3,  4'd6,  1'b1, 1'b0, 1'b0, 4'd9},
    {4'd14, 4'd1,  1'b1, 1'b1, 1'b1, 4'd7},
    {4'd0,  4'd15, 1'b0, 1'b0, 1'b1, 4'd0},
    {4'd5,  4'd4,  1'b0, 1'b0, 1'b0, 4'd0}
  };

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; cmd_we = 1'b0;
    cmd_addr = '0; cmd_wdata = '0; start = 1'b0; rx_addr = '0; inv_miso = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(ctl_rdata == 16'h0, "R1", "ctl after reset", int'(ctl_rdata), 0);
    chk(cs_o == 4'h0, "R1", "cs after reset", int'(cs_o), 0);
    chk(!finished && !done, "R1", "flags after reset", int'({finished, done}), 0);
    chk(!sclk && !xfer_active, "R1", "sclk/active after reset", int'({sclk, xfer_active}), 0);

    // R11 field readback, cpt field write ignored
    write_ctl(16'hFFA5);
    chk(ctl_rdata == 16'hF0A5, "R11", "ctl readback", int'(ctl_rdata), 16'hF0A5);
    chk(cs_o == 4'hF, "R4", "idle high cs", int'(cs_o), 4'hF);
    write_ctl(16'h0000);
    chk(cs_o == 4'h0, "R4", "idle low cs", int'(cs_o), 0);

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cmd_we = 1'b1; cmd_addr = 4'(i); cmd_wdata = {csp(i), dat(i)};
    end
    @(negedge clk) cmd_we = 1'b0;

    for (int v = 0; v < 7; v++) begin
      int st, en, hk, ec;
      bit wr, wt, cv;
      string tag;
      st = int'(VEC[v][14:11]); en = int'(VEC[v][10:7]);
      wr = VEC[v][6]; wt = VEC[v][5]; cv = VEC[v][4]; hk = int'(VEC[v][3:0]);
      ec = (hk == 0) ? (((en - st) & 15) + 1) : 0;
      tag = wr ? (wt ? "R7" : "R6") : "R2";
      run_queue(st, en, wr, wt, cv, 1'b0, hk, ec, 1'b0, tag);
    end

    // R5: start with halt already set runs one entry
    run_queue(9, 12, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1, 1'b0, "R5");
    // R10: start during a run is ignored
    run_queue(2, 4, 1'b0, 1'b0, 1'b0, 1'b0, 0, 3, 1'b1, "R10");
    // R3: receive RAM holds miso data, not mosi data
    inv_miso = 1'b1;
    run_queue(6, 6, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1, 1'b0, "R3");
    inv_miso = 1'b0;
    rx_addr = 4'd7;
    #1;
    chk(rx_data == dat(7), "R3", "untouched rx entry", int'(rx_data), int'(dat(7)));

    report();
    $finish;
  end
endmodule